// File: doc/BRIEF.md
# Receive Byte FIFO with Threshold Flag and DMA Request

This block sits between a serial receiver and the system bus. The receiver offers one byte per cycle, with two qualifiers: parity was correct, and the byte arrived without a framing or line error. Only a byte with both qualifiers set is stored. The store is four bytes deep and holds only data bytes. The bus side pops bytes one at a time, either from an interrupt handler or from a DMA engine.

A running occupancy count is compared against a 4-bit programmable threshold. A match raises a threshold flag. The flag drives an interrupt output through a mask bit. When DMA mode is on, the flag also starts a DMA read request, which stays high until the store has been drained. A byte that arrives while the store is full is dropped and sets a sticky overflow flag. Software clears that flag with a write-one strobe. A flush strobe empties the store. A bus write to the data port is not stored and returns an error response.

All logic runs on one clock. Status is registered, so it shows the occupancy of the cycle that has just completed.

Top module: `rx_byte_fifo`

## Requirements
- R1: After reset `level` is 0, and `thrFlag`, `ovfFlag`, `dmaReq` and `busErr` are all 0. Accepted bytes leave through `busRdata` in the order they arrived. `level` holds the number of stored bytes, from 0 to 4.
- R2: A byte offered with `rxParityOk` = 0 or `rxErrFree` = 0 is not stored, and `level` does not change because of it.
- R3: After every clock edge, `thrFlag` is 1 exactly when the new `level`, zero-extended to 4 bits, equals `rxThreshold`.
- R4: `irqOut` equals `thrFlag` AND NOT `irqMask`.
- R5: With `dmaEnable` = 1, `dmaReq` goes to 1 on the edge where `level` becomes equal to `rxThreshold` and is non-zero. It stays at 1 until `level` reaches 0. It is 0 whenever `dmaEnable` = 0 or a flush occurs.
- R6: If a valid byte arrives when `level` is 4 and there is no pop, the byte is discarded. The four stored bytes are unchanged and `ovfFlag` becomes 1.
- R7: `ovfFlag` is sticky. Reads do not clear it. A pulse on `ovfClear` clears it, except in a cycle where a new overflow happens, when setting takes priority.
- R8: A valid push and a pop in the same cycle on a full store act as a pop followed by a push. `level` stays 4 and `ovfFlag` is not set.
- R9: A `flush` pulse sets `level` to 0, clears `ovfFlag` and `dmaReq`, and overrides any push or pop in the same cycle. The next accepted byte is then the first byte read.
- R10: `busWrite` gives `busErr` = 1 in the following cycle. The written data is not stored and `level` is unchanged.
- R11: A read with `level` = 0 returns `busRdata` = 0 and leaves `level` and the stored order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxValid | input | 1 | Receiver offers a byte this cycle |
| rxByte | input | 8 | Received data byte |
| rxParityOk | input | 1 | Parity of the offered byte was correct |
| rxErrFree | input | 1 | Offered byte arrived without error |
| busRead | input | 1 | Pop the oldest byte at the clock edge |
| busWrite | input | 1 | Bus write to the data port (rejected) |
| busRdata | output | 8 | Oldest stored byte, or 0 when empty |
| busErr | output | 1 | Error response, one cycle after a write |
| rxThreshold | input | 4 | Occupancy value that raises the threshold flag |
| irqMask | input | 1 | 1 masks the threshold interrupt |
| dmaEnable | input | 1 | Enables the DMA read request |
| flush | input | 1 | Empties the store |
| ovfClear | input | 1 | Write-one-to-clear for the overflow flag |
| level | output | 3 | Number of stored bytes |
| thrFlag | output | 1 | Occupancy equals threshold |
| ovfFlag | output | 1 | Sticky overflow flag |
| irqOut | output | 1 | Masked threshold interrupt |
| dmaReq | output | 1 | DMA read request |

## Verification
The bench drives the store to full and keeps offering bytes. A design that overwrote the oldest entry, or let `level` run past 4, would then read back a wrong sequence. Two other boundary cases are a push and a pop together on a full store, and a set and a clear of the overflow flag in the same cycle. Getting the priority wrong in either case either reports a false overflow or loses a real one. The bench also lets the DMA request pass the threshold while pops drain the store. A request that followed the flag instead of latching would drop before the store was empty. Bad-parity bytes, bus writes, flushes that collide with pushes, and reads of an empty store are mixed into the random traffic to catch any path that writes or moves a pointer when it should not.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoStrobe_t;
endpackage

// File: rtl/rx_fifo_data.sv
module rx_fifo_data
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobe_t   strb,
  input  logic          empty,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= bump(wrPtr);
      if (strb.pop)  rdPtr <= bump(rdPtr);
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (strb.push && !strb.flush && wrPtr == AW'(i)) mem[i] <= wrData;
      end
    end
  endgenerate

  assign rdData = empty ? '0 : mem[rdPtr];

  a_r9_ptrs_aligned: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (wrPtr == rdPtr));
  a_r11_no_move_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !strb.push && !strb.flush) |=> $stable(rdPtr));
endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic             rxParityOk,
  input  logic             rxErrFree,
  input  logic             busRead,
  input  logic             busWrite,
  input  logic [THR_W-1:0] rxThreshold,
  input  logic             irqMask,
  input  logic             dmaEnable,
  input  logic             flush,
  input  logic             ovfClear,
  output fifoStrobe_t      strb,
  output logic             empty,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic             thrFlag,
  output logic             ovfFlag,
  output logic             irqOut,
  output logic             dmaReq,
  output logic             busErr
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count, countNext;
  logic goodByte, full, ovfHit, dmaNext;

  assign goodByte = rxValid && rxParityOk && rxErrFree;
  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);

  assign strb.flush = flush;
  assign strb.pop   = busRead && !empty && !flush;
  assign strb.push  = goodByte && !flush && (!full || strb.pop);
  assign ovfHit     = goodByte && !flush && full && !strb.pop;

  always_comb begin
    if (flush) countNext = '0;
    else countNext = count + CW'(strb.push) - CW'(strb.pop);
  end

  assign dmaNext = dmaEnable && !flush && (countNext != '0) &&
                   (dmaReq || (THR_W'(countNext) == rxThreshold));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      thrFlag <= 1'b0;
      ovfFlag <= 1'b0;
      dmaReq  <= 1'b0;
      busErr  <= 1'b0;
    end else begin
      count   <= countNext;
      thrFlag <= (THR_W'(countNext) == rxThreshold);
      dmaReq  <= dmaNext;
      busErr  <= busWrite;
      if (flush)         ovfFlag <= 1'b0;
      else if (ovfHit)   ovfFlag <= 1'b1;
      else if (ovfClear) ovfFlag <= 1'b0;
    end
  end

  assign level  = count;
  assign irqOut = thrFlag && !irqMask;

  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  a_r2_bad_byte_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !(rxParityOk && rxErrFree) && !busRead && !flush) |=> $stable(level));
  a_r6_overflow_keeps_full: assert property (@(posedge clk) disable iff (!rstN)
    (goodByte && full && !busRead && !flush) |=> (level == CW'(DEPTH) && ovfFlag));
  a_r7_read_keeps_ovf: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClear && !flush) |=> ovfFlag);
  a_r8_full_swap: assert property (@(posedge clk) disable iff (!rstN)
    (goodByte && full && busRead && !flush && !ovfFlag && !ovfClear) |=> (level == CW'(DEPTH) && !ovfFlag));
  a_r5_dma_holds: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && dmaEnable && !flush && !(busRead && level == CW'(1) && !goodByte)) |=> dmaReq);
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (level == '0 && !dmaReq && !ovfFlag));
  a_r10_write_error: assert property (@(posedge clk) disable iff (!rstN)
    busWrite |=> busErr);
endmodule

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DW = 8,
  parameter int THR_W = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic [DW-1:0]    rxByte,
  input  logic             rxParityOk,
  input  logic             rxErrFree,
  input  logic             busRead,
  input  logic             busWrite,
  output logic [DW-1:0]    busRdata,
  output logic             busErr,
  input  logic [THR_W-1:0] rxThreshold,
  input  logic             irqMask,
  input  logic             dmaEnable,
  input  logic             flush,
  input  logic             ovfClear,
  output logic [CW-1:0]    level,
  output logic             thrFlag,
  output logic             ovfFlag,
  output logic             irqOut,
  output logic             dmaReq
);
  fifoStrobe_t strb;
  logic empty;

  rx_fifo_ctrl #(.DEPTH(DEPTH), .THR_W(THR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .rxValid(rxValid), .rxParityOk(rxParityOk), .rxErrFree(rxErrFree),
    .busRead(busRead), .busWrite(busWrite),
    .rxThreshold(rxThreshold), .irqMask(irqMask), .dmaEnable(dmaEnable),
    .flush(flush), .ovfClear(ovfClear),
    .strb(strb), .empty(empty), .level(level),
    .thrFlag(thrFlag), .ovfFlag(ovfFlag), .irqOut(irqOut),
    .dmaReq(dmaReq), .busErr(busErr)
  );

  rx_fifo_data #(.DEPTH(DEPTH), .DW(DW)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .empty(empty),
    .wrData(rxByte), .rdData(busRdata)
  );
endmodule

// File: tb/rx_byte_fifo_bench.sv
module rx_byte_fifo_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxValid = 0, rxParityOk = 0, rxErrFree = 0;
  logic [7:0] rxByte = 0;
  logic busRead = 0, busWrite = 0, irqMask = 0, dmaEnable = 0, flush = 0, ovfClear = 0;
  logic [3:0] rxThreshold = 4'd2;
  logic [7:0] busRdata;
  logic busErr, thrFlag, ovfFlag, irqOut, dmaReq;
  logic [2:0] level;

  int checks = 0, fails = 0;
  logic [7:0] q [4];
  int n = 0;
  logic mOvf = 0, mDma = 0, mErr = 0, mThr = 0;

  always #2.5 clk = ~clk;

  rx_byte_fifo u_rx_byte_fifo (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
    .rxParityOk(rxParityOk), .rxErrFree(rxErrFree), .busRead(busRead),
    .busWrite(busWrite), .busRdata(busRdata), .busErr(busErr),
    .rxThreshold(rxThreshold), .irqMask(irqMask), .dmaEnable(dmaEnable),
    .flush(flush), .ovfClear(ovfClear), .level(level), .thrFlag(thrFlag),
    .ovfFlag(ovfFlag), .irqOut(irqOut), .dmaReq(dmaReq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic expIrq(input logic thr, input logic msk);
    return thr && !msk;
  endfunction

  // Advance the reference model by one clock edge with the current inputs.
  task automatic modelEdge();
    logic good;
    logic ovfSet;
    good = rxValid && rxParityOk && rxErrFree;
    ovfSet = 0;
    mErr = busWrite;
    if (flush) begin
      n = 0; mOvf = 0; mDma = 0;
    end else begin
      if (busRead && n > 0) begin
        for (int i = 0; i < 3; i++) q[i] = q[i+1];
        n--;
      end
      if (good) begin
        if (n < 4) begin q[n] = rxByte; n++; end
        else ovfSet = 1;
      end
      if (ovfSet) mOvf = 1;
      else if (ovfClear) mOvf = 0;
      mDma = dmaEnable && (n != 0) && (mDma || (n == int'(rxThreshold)));
    end
    mThr = (n == int'(rxThreshold));
  endtask

  // Inputs are set at a falling edge; read data is checked before the
  // rising edge, registered outputs at the next falling edge.
  task automatic step();
    #1;
    if (busRead) chk(n == 0 ? "R11 empty read data" : "R1 read order", int'(busRdata), n == 0 ? 0 : int'(q[0]));
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    chk("R1 level", int'(level), n);
    chk("R3 threshold flag", int'(thrFlag), int'(mThr));
    chk("R4 interrupt", int'(irqOut), int'(expIrq(mThr, irqMask)));
    chk("R5 dma request", int'(dmaReq), int'(mDma));
    chk("R6 R7 overflow flag", int'(ovfFlag), int'(mOvf));
    chk("R10 bus error", int'(busErr), int'(mErr));
  endtask

  task automatic idle();
    rxValid = 0; busRead = 0; busWrite = 0; flush = 0; ovfClear = 0;
    rxParityOk = 1; rxErrFree = 1;
  endtask

  task automatic pushByte(input logic [7:0] b);
    idle(); rxValid = 1; rxByte = b; step();
  endtask

  task automatic popByte();
    idle(); busRead = 1; step();
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    chk("R1 reset level", int'(level), 0);
    chk("R1 reset ovf", int'(ovfFlag), 0);
    chk("R1 reset dma", int'(dmaReq), 0);
    chk("R1 reset err", int'(busErr), 0);

    // R11: read empty
    popByte();
    // R2: bad parity and error bytes dropped
    idle(); rxValid = 1; rxByte = 8'hAA; rxParityOk = 0; step();
    idle(); rxValid = 1; rxByte = 8'hBB; rxErrFree = 0; step();
    // R6: fill and overflow
    rxThreshold = 4'd4; dmaEnable = 1;
    pushByte(8'h11); pushByte(8'h22); pushByte(8'h33); pushByte(8'h44);
    pushByte(8'h55);
    // R7: read does not clear; set beats clear
    popByte();
    pushByte(8'h66);
    idle(); rxValid = 1; rxByte = 8'h77; ovfClear = 1; step();
    idle(); ovfClear = 1; step();
    // R8: push and pop on full
    idle(); rxValid = 1; rxByte = 8'h88; busRead = 1; step();
    // R5: dma held while draining
    popByte(); popByte(); popByte(); popByte(); popByte();
    // R10: write rejected
    idle(); busWrite = 1; rxByte = 8'hEE; step();
    // R9: flush beats push
    pushByte(8'h01); pushByte(8'h02);
    idle(); flush = 1; rxValid = 1; rxByte = 8'h03; step();
    pushByte(8'h04); popByte();

    // Random traffic
    void'($urandom(32'd4242));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom();
      idle();
      rxValid    = r[0] | r[1];
      rxByte     = r[15:8];
      rxParityOk = r[2] | r[3] | r[4];
      rxErrFree  = r[5] | r[6] | r[7];
      busRead    = r[16] & r[17];
      busWrite   = (r[20:18] == 3'd0);
      flush      = (r[26:21] == 6'd0);
      ovfClear   = (r[29:27] == 3'd0);
      irqMask    = r[30];
      if (i % 200 == 0) begin
        rxThreshold = 4'($urandom_range(0, 5));
        dmaEnable = r[31];
      end
      step();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule